// File: doc/BRIEF.md
# Accumulator Execution Unit with Condition Flags

This block is the byte-wide execution stage of a small microcontroller core. Each cycle it can take one already-decoded operation. The operation carries an operation code, an 8-bit immediate, a file-register address, a second address used only by the copy operation, and a one-bit destination select. The operand byte comes from an external file-register read port, which is asynchronous and addressed by the unit.

The unit computes a result. It then loads that result into its working register or presents it on a file-register write port. It also updates a five-bit condition register. The operations are:

- load an immediate into the working register;
- add an immediate to the working register;
- store the working register to a file register;
- add a file register to the working register;
- invert, decrement or pass through a file register;
- copy one file register to another without touching the working register.

Complement and decrement are read-modify-write operations. When the destination select is 1, the operand is read and the new value is written back to the same address in the same cycle. Passing a register through onto itself is the way to refresh the zero and negative flags from a stored byte.

The copy uses two cycles and holds the byte in an internal register between them. The file-register storage, instruction fetch and decode are outside the block.

Top module: `acc_exec_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the working register, the whole condition register and `busy` become 0.
- R2: Operation code 1 (load immediate) puts `lit` into the working register and leaves the condition register unchanged.
- R3: Operation code 2 (add immediate) puts the low 8 bits of working register + `lit` into the working register. It updates all five flags. The `status` bits are: bit 0 carry out of bit 7, bit 1 carry out of bit 3, bit 2 result zero, bit 3 two's-complement overflow, bit 4 result bit 7.
- R4: Operation code 3 (store) drives `fwr_en`=1, `fwr_addr`=`faddr` and `fwr_data`=working register in the issue cycle, and leaves the flags and working register unchanged. Operation codes 1 and 2 never assert `fwr_en`.
- R5: For operation codes 4 to 7, `dst`=0 loads the result into the working register with no file write. `dst`=1 writes the result to `faddr` in the issue cycle and leaves the working register unchanged.
- R6: Operation code 4 adds the working register and the file byte, and updates all five flags as in R3.
- R7: Operation code 5 produces the bitwise inverse of the file byte. It updates only the zero and negative flags.
- R8: Operation code 6 produces the file byte minus 1 and updates all five flags. Carry is 1 when no borrow occurs (byte not 0). The bit-3 carry is 1 when the low nibble is not 0. Overflow is 1 only for byte 80h.
- R9: Operation code 7 passes the file byte through and updates only the zero and negative flags. With `dst`=1 it writes the same byte back.
- R10: Operation code 8 (copy) reads `faddr` in the issue cycle. In the next cycle `busy` is 1 and the byte is written to `cdst_addr`. The working register and flags do not change.
- R11: An operation presented while `busy` is 1 is ignored. So are code 0, codes 9 to 15, and any operation with `op_valid` low: none of them changes the working register or the flags, or writes a file register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Decoded operation code |
| lit | input | 8 | Immediate operand |
| faddr | input | 8 | File-register operand / destination address |
| dst | input | 1 | 0: working register, 1: file register |
| cdst_addr | input | 8 | Copy destination address |
| frd_addr | output | 8 | File-register read address |
| frd_data | input | 8 | File-register read data (asynchronous) |
| fwr_en | output | 1 | File-register write enable |
| fwr_addr | output | 8 | File-register write address |
| fwr_data | output | 8 | File-register write data |
| wreg | output | 8 | Working register |
| status | output | 5 | Condition flags {N, OV, Z, DC, C} |
| busy | output | 1 | Copy write cycle in progress |

## Verification
The hardest case to reach from the ports is a flag update that must keep some of the flags. Inverting or passing through a byte must leave carry, digit carry and overflow exactly as an earlier arithmetic operation left them. The stimulus first runs additions and decrements chosen to set those flags, for example 7Fh+01h, a decrement of 80h, and a decrement of 01h. It then issues the logic operations and checks the whole status vector. A second hard case is an operation presented during the copy's write cycle. The bench holds a load-immediate on the inputs exactly while `busy` is high, and then confirms that the working register still has its old value.

// File: rtl/acc_pkg.sv
// Shared types for the accumulator execution unit.
// Assumes a 4-bit operation code and a five-flag condition register.
package acc_pkg;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_LDLIT  = 4'd1,
        OP_ADDLIT = 4'd2,
        OP_STW    = 4'd3,
        OP_ADDF   = 4'd4,
        OP_INVF   = 4'd5,
        OP_DECF   = 4'd6,
        OP_MOVF   = 4'd7,
        OP_COPY   = 4'd8
    } op_e;

    // Bit 0 is carry; field order fixes the status port layout.
    typedef struct packed {
        logic n;
        logic ov;
        logic z;
        logic dc;
        logic c;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

endpackage

// File: rtl/acc_alu.sv
// Combinational datapath: selects operands, adds, and forms result, new
// flags, a flag-update mask and the two write enables.
// Assumes op is already forced to OP_NOP when the operation is not accepted.
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] w,
    input  logic [DATA_W-1:0] lit,
    input  logic [DATA_W-1:0] fval,
    input  logic              dst,
    output logic [DATA_W-1:0] res,
    output flags_t            flg,
    output flags_t            upd,
    output logic              we_w,
    output logic              we_f
);
    localparam int NIB = 4;
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] opa, opb;
    logic [DATA_W:0]   sum;
    logic [NIB:0]      low_sum;

    // Operand selection for the shared adder.
    always_comb begin
        opa = w;
        opb = lit;
        case (op)
            OP_ADDF: opb = fval;
            OP_DECF: begin
                opa = fval;
                opb = '1;
            end
            default: ;
        endcase
    end

    // Shared adder with low-nibble carry.
    always_comb begin
        sum     = {1'b0, opa} + {1'b0, opb};
        low_sum = {1'b0, opa[NIB-1:0]} + {1'b0, opb[NIB-1:0]};
    end

    // Result, flag values, flag mask and destination decode.
    always_comb begin
        res  = '0;
        upd  = '0;
        we_w = 1'b0;
        we_f = 1'b0;
        case (op)
            OP_LDLIT: begin
                res  = lit;
                we_w = 1'b1;
            end
            OP_ADDLIT: begin
                res  = sum[DATA_W-1:0];
                upd  = '1;
                we_w = 1'b1;
            end
            OP_STW: begin
                res  = w;
                we_f = 1'b1;
            end
            OP_ADDF, OP_DECF: begin
                res  = sum[DATA_W-1:0];
                upd  = '1;
                we_w = ~dst;
                we_f = dst;
            end
            OP_INVF: begin
                res   = ~fval;
                upd.z = 1'b1;
                upd.n = 1'b1;
                we_w  = ~dst;
                we_f  = dst;
            end
            OP_MOVF: begin
                res   = fval;
                upd.z = 1'b1;
                upd.n = 1'b1;
                we_w  = ~dst;
                we_f  = dst;
            end
            default: ;
        endcase
        flg.c  = sum[DATA_W];
        flg.dc = low_sum[NIB];
        flg.ov = (opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB]);
        flg.z  = (res == '0);
        flg.n  = res[MSB];
    end

    // R4 literal operations never target the file port
    always_comb begin
        lit_no_file_chk: assert (!((op == OP_LDLIT || op == OP_ADDLIT) && we_f));
    end

endmodule

// File: rtl/acc_copy_ctrl.sv
// Two-cycle file-to-file copy: captures the source byte and destination
// address on start, then presents them for one write cycle.
// Assumes start is never raised while pending is high.
module acc_copy_ctrl #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] src_data,
    input  logic [ADDR_W-1:0] dst_addr,
    output logic              pending,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    // Holding registers and the write-pending bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            pending <= start;
            if (start) begin
                wr_addr <= dst_addr;
                wr_data <= src_data;
            end
        end
    end

    // R10
    // copy_once_chk: the write cycle lasts exactly one cycle
    copy_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> !pending);

    // R10
    // copy_start_chk: a start is followed by the write cycle
    copy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> pending);

    // R11
    // copy_no_overlap_chk: no new copy starts during a write cycle
    copy_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !start);

endmodule

// File: rtl/acc_state_regs.sv
// Working register and condition register with per-flag update mask.
// Assumes the mask is zero for operations that keep all flags.
module acc_state_regs
    import acc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w_we,
    input  logic [DATA_W-1:0] w_d,
    input  flags_t            flg_d,
    input  flags_t            flg_upd,
    output logic [DATA_W-1:0] wreg,
    output flags_t            flags
);
    // Working register load.
    always_ff @(posedge clk) begin
        if (!rst_n)    wreg <= '0;
        else if (w_we) wreg <= w_d;
    end

    // Merge new flag values under the update mask.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flg_upd) | (flg_d & flg_upd);
    end

    // R1
    // reset_clear_chk: reset empties both registers
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (wreg == '0 && flags == '0));

endmodule

// File: rtl/acc_exec_unit.sv
// Top of the accumulator execution unit: accepts one decoded operation per
// cycle unless a copy write is pending, drives the file-register ports and
// holds the working and condition registers.
// Assumes an asynchronous file-register read and a write on the clock edge.
module acc_exec_unit
    import acc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int OP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] lit,
    input  logic [ADDR_W-1:0] faddr,
    input  logic              dst,
    input  logic [ADDR_W-1:0] cdst_addr,
    output logic [ADDR_W-1:0] frd_addr,
    input  logic [DATA_W-1:0] frd_data,
    output logic              fwr_en,
    output logic [ADDR_W-1:0] fwr_addr,
    output logic [DATA_W-1:0] fwr_data,
    output logic [DATA_W-1:0] wreg,
    output logic [FLAG_W-1:0] status,
    output logic              busy
);
    logic              accept;
    op_e               op_eff;
    logic [DATA_W-1:0] alu_res;
    flags_t            alu_flg, alu_upd, flags_q;
    logic              alu_we_w, alu_we_f;
    logic              copy_start, copy_pend;
    logic [ADDR_W-1:0] copy_addr;
    logic [DATA_W-1:0] copy_data;

    // Gate the operation: drop it while a copy write is pending.
    always_comb begin
        accept     = op_valid && !copy_pend;
        op_eff     = accept ? op_e'(op_code) : OP_NOP;
        copy_start = (op_eff == OP_COPY);
    end

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .op   (op_eff),
        .w    (wreg),
        .lit  (lit),
        .fval (frd_data),
        .dst  (dst),
        .res  (alu_res),
        .flg  (alu_flg),
        .upd  (alu_upd),
        .we_w (alu_we_w),
        .we_f (alu_we_f)
    );

    acc_copy_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_copy (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (copy_start),
        .src_data (frd_data),
        .dst_addr (cdst_addr),
        .pending  (copy_pend),
        .wr_addr  (copy_addr),
        .wr_data  (copy_data)
    );

    acc_state_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .w_we    (alu_we_w),
        .w_d     (alu_res),
        .flg_d   (alu_flg),
        .flg_upd (alu_upd),
        .wreg    (wreg),
        .flags   (flags_q)
    );

    // File-register port steering: the copy write wins its cycle.
    always_comb begin
        frd_addr = faddr;
        fwr_en   = copy_pend | alu_we_f;
        fwr_addr = copy_pend ? copy_addr : faddr;
        fwr_data = copy_pend ? copy_data : alu_res;
        status   = flags_q;
        busy     = copy_pend;
    end

    // R2
    // flags_keep_chk: load-immediate, store and copy keep the flags
    flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_eff == OP_LDLIT || op_eff == OP_STW || op_eff == OP_COPY)
        |=> $stable(status));

    // R5
    // file_dst_keeps_w_chk: file-destination operations keep the working register
    file_dst_keeps_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst && (op_eff == OP_ADDF || op_eff == OP_INVF ||
                 op_eff == OP_DECF || op_eff == OP_MOVF)) |=> $stable(wreg));

    // R11
    // busy_ignore_chk: nothing presented in a write cycle changes state
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(wreg) && $stable(status)));

    // R10
    // copy_write_chk: the write cycle always drives the file port
    copy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> fwr_en);

endmodule

// File: tb/acc_exec_unit_tb.sv
module acc_exec_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] lit = 8'h00;
    logic [7:0] faddr = 8'h00;
    logic       dst = 1'b0;
    logic [7:0] cdst_addr = 8'h00;
    logic [7:0] frd_addr, frd_data, fwr_addr, fwr_data, wreg;
    logic       fwr_en, busy;
    logic [4:0] status;

    int checks = 0;
    int errors = 0;
    logic       pre_en = 1'b0;
    logic [7:0] pre_addr = 8'h00, pre_data = 8'h00;
    logic [7:0] mem [256];
    logic       s_fen;
    logic [7:0] s_faddr, s_fdata;

    always #5 clk = ~clk;

    acc_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .lit(lit), .faddr(faddr), .dst(dst), .cdst_addr(cdst_addr),
        .frd_addr(frd_addr), .frd_data(frd_data), .fwr_en(fwr_en),
        .fwr_addr(fwr_addr), .fwr_data(fwr_data), .wreg(wreg),
        .status(status), .busy(busy)
    );

    // File-register model: asynchronous read, write on the edge.
    assign frd_data = mem[frd_addr];
    always @(posedge clk) begin
        if (pre_en) mem[pre_addr] <= pre_data;
        else if (fwr_en) mem[fwr_addr] <= fwr_data;
    end

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic preload(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        pre_en = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    // Present one operation for one cycle; capture the write port mid-cycle.
    task automatic issue(input logic [3:0] code, input logic [7:0] l,
                         input logic [7:0] a, input logic d, input logic [7:0] ca);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; lit = l; faddr = a; dst = d; cdst_addr = ca;
        #1;
        s_fen = fwr_en; s_faddr = fwr_addr; s_fdata = fwr_data;
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "wreg", wreg, 8'h00);
        chk("R1", "status", {3'b0, status}, 8'h00);
        chk("R1", "busy", {7'b0, busy}, 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic t_literal();
        issue(4'd1, 8'h25, 8'h00, 1'b0, 8'h00);
        chk("R2", "ldlit wreg", wreg, 8'h25);
        chk("R2", "ldlit status", {3'b0, status}, 8'h00);
        issue(4'd2, 8'h34, 8'h00, 1'b0, 8'h00);
        chk("R3", "25+34 wreg", wreg, 8'h59);
        chk("R3", "25+34 status", {3'b0, status}, 8'h00);
        chk("R4", "addlit no file write", {7'b0, s_fen}, 8'h00);
        issue(4'd2, 8'hA7, 8'h00, 1'b0, 8'h00);
        chk("R3", "59+A7 wreg", wreg, 8'h00);
        chk("R3", "59+A7 status C DC Z", {3'b0, status}, 8'h07);
        issue(4'd1, 8'h7F, 8'h00, 1'b0, 8'h00);
        chk("R2", "ldlit keeps flags", {3'b0, status}, 8'h07);
        chk("R4", "ldlit no file write", {7'b0, s_fen}, 8'h00);
        issue(4'd2, 8'h01, 8'h00, 1'b0, 8'h00);
        chk("R3", "7F+01 wreg", wreg, 8'h80);
        chk("R3", "7F+01 status DC OV N", {3'b0, status}, 8'h1A);
    endtask

    task automatic t_store();
        issue(4'd3, 8'h00, 8'h10, 1'b0, 8'h00);
        chk("R4", "store fwr_en", {7'b0, s_fen}, 8'h01);
        chk("R4", "store fwr_addr", s_faddr, 8'h10);
        chk("R4", "store fwr_data", s_fdata, 8'h80);
        chk("R4", "store mem", mem[8'h10], 8'h80);
        chk("R4", "store wreg", wreg, 8'h80);
        chk("R4", "store status", {3'b0, status}, 8'h1A);
    endtask

    task automatic t_invert();
        preload(8'h21, 8'hFF);
        preload(8'h22, 8'h0F);
        issue(4'd5, 8'h00, 8'h21, 1'b1, 8'h00);
        chk("R7", "invf FF to file", mem[8'h21], 8'h00);
        chk("R5", "invf dst=1 keeps wreg", wreg, 8'h80);
        chk("R7", "invf keeps DC OV, sets Z", {3'b0, status}, 8'h0E);
        issue(4'd5, 8'h00, 8'h22, 1'b0, 8'h00);
        chk("R7", "invf 0F to wreg", wreg, 8'hF0);
        chk("R5", "invf dst=0 no write", {7'b0, s_fen}, 8'h00);
        chk("R5", "invf dst=0 mem kept", mem[8'h22], 8'h0F);
        chk("R7", "invf status N", {3'b0, status}, 8'h1A);
    endtask

    task automatic t_addf();
        preload(8'h20, 8'h05);
        preload(8'h23, 8'h0B);
        issue(4'd4, 8'h00, 8'h20, 1'b0, 8'h00);
        chk("R6", "F0+05 wreg", wreg, 8'hF5);
        chk("R6", "F0+05 status", {3'b0, status}, 8'h10);
        issue(4'd4, 8'h00, 8'h20, 1'b1, 8'h00);
        chk("R5", "F5+05 to file", mem[8'h20], 8'hFA);
        chk("R5", "addf dst=1 keeps wreg", wreg, 8'hF5);
        issue(4'd4, 8'h00, 8'h23, 1'b1, 8'h00);
        chk("R6", "F5+0B to file", mem[8'h23], 8'h00);
        chk("R6", "F5+0B status C DC Z", {3'b0, status}, 8'h07);
    endtask

    task automatic t_decrement();
        preload(8'h24, 8'h00);
        preload(8'h25, 8'h80);
        preload(8'h26, 8'h01);
        issue(4'd6, 8'h00, 8'h24, 1'b1, 8'h00);
        chk("R8", "dec 00 to file", mem[8'h24], 8'hFF);
        chk("R8", "dec 00 borrow status", {3'b0, status}, 8'h10);
        issue(4'd6, 8'h00, 8'h25, 1'b0, 8'h00);
        chk("R8", "dec 80 wreg", wreg, 8'h7F);
        chk("R8", "dec 80 status C OV", {3'b0, status}, 8'h09);
        issue(4'd6, 8'h00, 8'h26, 1'b0, 8'h00);
        chk("R8", "dec 01 wreg", wreg, 8'h00);
        chk("R8", "dec 01 status C DC Z", {3'b0, status}, 8'h07);
    endtask

    task automatic t_move();
        preload(8'h28, 8'h9C);
        preload(8'h27, 8'h00);
        issue(4'd7, 8'h00, 8'h28, 1'b0, 8'h00);
        chk("R9", "movf wreg", wreg, 8'h9C);
        chk("R9", "movf status N keeps C DC", {3'b0, status}, 8'h13);
        issue(4'd7, 8'h00, 8'h27, 1'b1, 8'h00);
        chk("R9", "movf self write en", {7'b0, s_fen}, 8'h01);
        chk("R9", "movf self data", s_fdata, 8'h00);
        chk("R9", "movf self status Z", {3'b0, status}, 8'h07);
        chk("R9", "movf self keeps wreg", wreg, 8'h9C);
    endtask

    task automatic t_copy();
        preload(8'h30, 8'hAB);
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd8; faddr = 8'h30; cdst_addr = 8'h31;
        #1;
        chk("R10", "copy no write in read cycle", {7'b0, fwr_en}, 8'h00);
        @(negedge clk);
        op_code = 4'd1; lit = 8'h55;
        #1;
        chk("R10", "copy busy", {7'b0, busy}, 8'h01);
        chk("R10", "copy fwr_en", {7'b0, fwr_en}, 8'h01);
        chk("R10", "copy fwr_addr", fwr_addr, 8'h31);
        chk("R10", "copy fwr_data", fwr_data, 8'hAB);
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd0;
        chk("R10", "copy mem", mem[8'h31], 8'hAB);
        chk("R10", "copy busy cleared", {7'b0, busy}, 8'h00);
        chk("R11", "op while busy ignored", wreg, 8'h9C);
        chk("R10", "copy keeps status", {3'b0, status}, 8'h07);
    endtask

    task automatic t_ignored();
        issue(4'd15, 8'h11, 8'h40, 1'b1, 8'h00);
        chk("R11", "code 15 no write", {7'b0, s_fen}, 8'h00);
        chk("R11", "code 15 wreg", wreg, 8'h9C);
        chk("R11", "code 15 status", {3'b0, status}, 8'h07);
        issue(4'd0, 8'h11, 8'h40, 1'b0, 8'h00);
        chk("R11", "nop wreg", wreg, 8'h9C);
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd2; lit = 8'h01;
        #1;
        chk("R11", "invalid no write", {7'b0, fwr_en}, 8'h00);
        @(negedge clk);
        op_code = 4'd0;
        chk("R11", "invalid add ignored", wreg, 8'h9C);
        chk("R11", "invalid status", {3'b0, status}, 8'h07);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        t_reset();
        t_literal();
        t_store();
        t_invert();
        t_addf();
        t_decrement();
        t_move();
        t_copy();
        t_ignored();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule